// File: doc/BRIEF.md
# I2C Target Receive Path with Overflow Protection

This block is the receive half of an I2C target (slave). It oversamples the SCL and SDA lines on a system clock that runs much faster than SCL. It finds START and STOP conditions on the bus, shifts in the first byte after each START, and compares the upper seven bits of that byte with a programmed address. When the address matches, the block keeps that address byte and every data byte that follows until the next START or STOP. Each kept byte goes into a single-byte holding register. During the ninth clock of each byte the block acknowledges it by pulling SDA low, unless it cannot accept the byte.

The host side sees the holding register and a small set of flags:

- **Byte-held**: the holding register has a byte that has not yet been read.
- **Lost-byte**: a byte arrived while an unread byte was still held.
- **Direction**: the R/W bit of the last matched address.
- **Kind**: whether the last stored byte was an address or data.
- **Event**: a per-byte event flag.

The host drives one-cycle pulses to read the holding register, to clear the event flag and to clear the lost-byte flag.

The block never accepts a byte while either the byte-held or the lost-byte flag is set. The one exception concerns storage: when the lost-byte flag is still set but the holding register has already been read, the next byte is stored and is still not acknowledged. This makes the host clear the lost-byte condition explicitly before the bus gets acknowledges again.

Top module: `i2c_target_rx`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception. After a STOP (SDA rising while SCL is high), bytes clocked on the bus get no ACK and do not set the event flag until the next START.
- R2: An address byte whose upper seven bits equal `own_addr` and whose bit 0 (R/W) is 0 is ACKed when both flags are clear. The whole 8-bit byte is stored in `rx_data`, `st_dir` becomes 0 and `st_data` becomes 0.
- R3: `sda_oe` (1 = pull SDA low) is high only from the SCL falling edge after the eighth bit of a matched byte until the SCL falling edge after the ninth bit. It is never high for a byte that arrives while `st_full` or `st_ovf` is set.
- R4: `irq` goes to 1 for every byte the block takes part in, whether it is stored or refused. It stays 1 until `clr_irq` is pulsed.
- R5: `st_full` goes to 1 when a byte is stored and to 0 when `rd_buf` is pulsed. Reading does not change `rx_data`.
- R6: A byte that arrives while `st_full` is 1 sets `st_ovf`, leaves `rx_data` unchanged and is not ACKed. `st_ovf` returns to 0 only on a `clr_ovf` pulse.
- R7: A byte that arrives while `st_ovf` is 1 and `st_full` is 0 is stored in `rx_data`, sets `st_full`, and is not ACKed.
- R8: `st_data` is 1 after a data byte is stored and 0 after an address byte is stored.
- R9: An address byte whose upper seven bits differ from `own_addr` is not ACKed. All bytes up to the next START then get no ACK, are not stored and leave every flag unchanged.
- R10: A matching address byte with R/W = 1 is stored and ACKed (flags permitting) and sets `st_dir` to 1. Later bytes in that transfer are not received.
- R11: A START in the middle of a byte abandons that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| own_addr | input | 7 | Programmed 7-bit target address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| rd_buf | input | 1 | Host pulse: read holding register, clears `st_full` |
| clr_irq | input | 1 | Host pulse: clear `irq` |
| clr_ovf | input | 1 | Host pulse: clear `st_ovf` |
| rx_data | output | 8 | Holding register contents |
| irq | output | 1 | Per-byte event flag |
| st_full | output | 1 | Holding register has an unread byte |
| st_ovf | output | 1 | A byte arrived while the register was full |
| st_dir | output | 1 | R/W bit of the last stored address |
| st_data | output | 1 | 1 when the last stored byte was data |

## Verification
Most internal faults in this block show up on `sda_oe` within the same byte. A wrong bit count shifts the ACK window. A wrong address compare or wrong flag gating turns an ACK into a NACK, or the reverse, on the ninth clock of the byte concerned. Faults in the flag logic show up later, at the next transfer: a byte-held flag that fails to clear gives an unexpected NACK, and a lost-byte flag that clears by itself lets the stored-but-refused case be ACKed. The bench checks both the ACK seen on the bus for each byte and the flag and register values after each transfer, so it covers both of these delays.

// File: rtl/i2c_target_rx_pkg.sv
// Shared types for the I2C target receive path.
package i2c_target_rx_pkg;

    // Receive engine states.
    typedef enum logic [2:0] {
        RX_IDLE = 3'd0,   // waiting for START
        RX_ADDR = 3'd1,   // shifting in the address byte
        RX_DATA = 3'd2,   // shifting in a data byte
        RX_ACK  = 3'd3,   // ninth clock: acknowledge slot
        RX_SKIP = 3'd4    // not addressed, wait for next START
    } rx_state_t;

    // One completed byte handed from the engine to the register file.
    typedef struct packed {
        logic       valid;   // one-cycle strobe
        logic [7:0] value;   // byte as received, MSB first
        logic       is_addr; // byte was the address byte
    } rx_byte_t;

endpackage

// File: rtl/i2c_target_rx_sync.sv
// Line conditioner: brings SCL and SDA into the clk domain through a
// STAGES-deep synchronizer chain and derives the SCL edges and the bus
// START/STOP conditions from the synchronized levels.
// Assumes clk is fast enough that each SCL phase spans several clk cycles.
module i2c_target_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;

    // Synchronizer chains, idle-high after reset like an idle bus.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // One-cycle history of the synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Edge and condition decode from current and previous levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        bus_start = scl_s & scl_prev & sda_prev & ~sda_s;
        bus_stop  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_target_rx_engine.sv
// Bit-level receive engine: shifts bits on SCL rising edges, matches the
// address, hands each completed byte to the register file on the SCL
// falling edge after its last bit, and drives the acknowledge slot.
// Assumes the register file answers ack_ok in the same cycle as the strobe.
module i2c_target_rx_engine
    import i2c_target_rx_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_ok,
    output rx_byte_t          byte_out,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    rx_state_t         state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              ack_en;
    logic              go_data;
    logic              byte_end;
    logic              addr_hit;

    // Byte boundary and address compare decode.
    always_comb begin
        byte_end = (state == RX_ADDR || state == RX_DATA) && scl_fall && (bitcnt == LAST_BIT);
        addr_hit = (shreg[BYTE_W-1 -: ADDR_W] == own_addr);
        byte_out.valid   = byte_end && (state == RX_DATA || addr_hit);
        byte_out.value   = shreg;
        byte_out.is_addr = (state == RX_ADDR);
    end

    // Engine state, shift register, bit counter and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            ack_en  <= 1'b0;
            go_data <= 1'b0;
        end else if (bus_start) begin
            state  <= RX_ADDR;
            bitcnt <= '0;
            ack_en <= 1'b0;
        end else if (bus_stop) begin
            state  <= RX_IDLE;
            bitcnt <= '0;
            ack_en <= 1'b0;
        end else begin
            case (state)
                RX_ADDR, RX_DATA: begin
                    if (scl_rise && bitcnt < LAST_BIT) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        if (state == RX_ADDR && !addr_hit) begin
                            state <= RX_SKIP;
                        end else begin
                            state   <= RX_ACK;
                            ack_en  <= ack_ok;
                            go_data <= (state == RX_DATA) || !shreg[0];
                        end
                    end
                end
                RX_ACK: begin
                    if (scl_rise) begin
                        bitcnt <= ACK_BIT;
                    end else if (scl_fall && bitcnt == ACK_BIT) begin
                        ack_en <= 1'b0;
                        bitcnt <= '0;
                        state  <= go_data ? RX_DATA : RX_SKIP;
                    end
                end
                default: begin
                    bitcnt <= '0;
                end
            endcase
        end
    end

    assign sda_oe = ack_en;

endmodule

// File: rtl/i2c_target_rx_regs.sv
// Host-side register file: single-byte holding register and flags.
// A byte is stored only while the holding register is empty; it is
// acknowledged only while both the full and lost-byte flags are clear.
// Assumes host pulses are one clk cycle wide; a byte strobe wins over a
// clear in the same cycle.
module i2c_target_rx_regs
    import i2c_target_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_byte_t          byte_in,
    input  logic              rd_buf,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    output logic              ack_ok,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq,
    output logic              st_full,
    output logic              st_ovf,
    output logic              st_dir,
    output logic              st_data
);
    logic store;

    // Store and acknowledge decisions from the flags before this byte.
    always_comb begin
        store  = byte_in.valid && !st_full;
        ack_ok = !st_full && !st_ovf;
    end

    // Holding register and the status of the byte it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            st_dir  <= 1'b0;
            st_data <= 1'b0;
        end else if (store) begin
            rx_data <= byte_in.value;
            st_data <= !byte_in.is_addr;
            if (byte_in.is_addr) begin
                st_dir <= byte_in.value[0];
            end
        end
    end

    // Full, lost-byte and event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_full <= 1'b0;
            st_ovf  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (store)       st_full <= 1'b1;
            else if (rd_buf) st_full <= 1'b0;

            if (byte_in.valid && st_full) st_ovf <= 1'b1;
            else if (clr_ovf)             st_ovf <= 1'b0;

            if (byte_in.valid) irq <= 1'b1;
            else if (clr_irq)  irq <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_target_rx.sv
// I2C target receive path top: line conditioner, bit engine and host
// register file. sda_oe must drive an open-drain pull-down on SDA; sda_i
// is the resolved line level. Assumes clk is at least 16x the SCL rate.
module i2c_target_rx
    import i2c_target_rx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_oe,
    input  logic              rd_buf,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq,
    output logic              st_full,
    output logic              st_ovf,
    output logic              st_dir,
    output logic              st_data
);
    logic     sda_s;
    logic     scl_rise;
    logic     scl_fall;
    logic     bus_start;
    logic     bus_stop;
    logic     ack_ok;
    rx_byte_t byte_evt;

    i2c_target_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_target_rx_engine #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .own_addr  (own_addr),
        .ack_ok    (ack_ok),
        .byte_out  (byte_evt),
        .sda_oe    (sda_oe)
    );

    i2c_target_rx_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_in (byte_evt),
        .rd_buf  (rd_buf),
        .clr_irq (clr_irq),
        .clr_ovf (clr_ovf),
        .ack_ok  (ack_ok),
        .rx_data (rx_data),
        .irq     (irq),
        .st_full (st_full),
        .st_ovf  (st_ovf),
        .st_dir  (st_dir),
        .st_data (st_data)
    );

endmodule

// File: rtl/i2c_target_rx_chk.sv
// Property checker for i2c_target_rx, attached by bind below.
module i2c_target_rx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              rd_buf,
    input logic              clr_irq,
    input logic              clr_ovf,
    input logic [BYTE_W-1:0] rx_data,
    input logic              irq,
    input logic              st_full,
    input logic              st_ovf
);
    AST_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (!$past(st_full) && !$past(st_ovf))); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq); // R4
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && !rd_buf) |=> st_full); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovf && !clr_ovf) |=> st_ovf); // R6
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |=> $stable(rx_data)); // R6
endmodule

bind i2c_target_rx i2c_target_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .rd_buf  (rd_buf),
    .clr_irq (clr_irq),
    .clr_ovf (clr_ovf),
    .rx_data (rx_data),
    .irq     (irq),
    .st_full (st_full),
    .st_ovf  (st_ovf)
);

// File: tb/i2c_target_rx_tb.sv
`timescale 1ns/1ps
module i2c_target_rx_tb;
    localparam int Q = 10;               // clk cycles per SCL quarter step
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       rd_buf = 1'b0, clr_irq = 1'b0, clr_ovf = 1'b0;
    logic [7:0] rx_data;
    logic       irq, st_full, st_ovf, st_dir, st_data;
    int         n_run = 0, n_fail = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_target_rx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .own_addr(OWN), .sda_oe(sda_oe), .rd_buf(rd_buf),
        .clr_irq(clr_irq), .clr_ovf(clr_ovf), .rx_data(rx_data),
        .irq(irq), .st_full(st_full), .st_ovf(st_ovf),
        .st_dir(st_dir), .st_data(st_data)
    );

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] data;
        logic       rd_mid;
        logic       aack;
        logic       dack;
        logic [7:0] buf_v;
        logic       full;
        logic       ovf;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{addr:7'h5A, data:8'h3C, rd_mid:1'b1, aack:1'b1, dack:1'b1, buf_v:8'h3C, full:1'b1, ovf:1'b0},
        '{addr:7'h5A, data:8'hA5, rd_mid:1'b0, aack:1'b1, dack:1'b0, buf_v:8'hB4, full:1'b1, ovf:1'b1},
        '{addr:7'h12, data:8'h77, rd_mid:1'b1, aack:1'b0, dack:1'b0, buf_v:8'hB4, full:1'b0, ovf:1'b0},
        '{addr:7'h5A, data:8'hFF, rd_mid:1'b1, aack:1'b1, dack:1'b1, buf_v:8'hFF, full:1'b1, ovf:1'b0},
        '{addr:7'h5A, data:8'h00, rd_mid:1'b1, aack:1'b1, dack:1'b1, buf_v:8'h00, full:1'b1, ovf:1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic pulse_rd();   @(negedge clk); rd_buf = 1'b1;  @(negedge clk); rd_buf = 1'b0;  endtask
    task automatic pulse_irq();  @(negedge clk); clr_irq = 1'b1; @(negedge clk); clr_irq = 1'b0; endtask
    task automatic pulse_ovf();  @(negedge clk); clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0; endtask

    task automatic host_clean();
        pulse_rd(); pulse_ovf(); pulse_irq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
        sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q(); scl = 1'b1; wait_q(); scl = 1'b0; wait_q();
    endtask

    // Sends 8 bits and the ninth clock; returns whether sda_oe was held.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q();
        ack = sda_oe;
        scl = 1'b1; wait_q();
        ack = ack & sda_oe;
        scl = 1'b0; wait_q();
    endtask

    logic a, d;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Reset state
        check("R5 reset full", {7'd0, st_full}, 8'd0);
        check("R6 reset ovf", {7'd0, st_ovf}, 8'd0);
        check("R4 reset irq", {7'd0, irq}, 8'd0);
        check("R3 reset oe", {7'd0, sda_oe}, 8'd0);

        // Table walk: address + one data byte per vector
        for (int v = 0; v < 5; v++) begin
            host_clean();
            bus_start();
            send_byte({VEC[v].addr, 1'b0}, a);
            if (VEC[v].rd_mid) pulse_rd();
            send_byte(VEC[v].data, d);
            check("R3 oe released after ack", {7'd0, sda_oe}, 8'd0);
            bus_stop();
            check("R2/R9 address ack", {7'd0, a}, {7'd0, VEC[v].aack});
            check("R3/R6 data ack", {7'd0, d}, {7'd0, VEC[v].dack});
            check("R5/R6 buffer", rx_data, VEC[v].buf_v);
            check("R5 full", {7'd0, st_full}, {7'd0, VEC[v].full});
            check("R6 ovf", {7'd0, st_ovf}, {7'd0, VEC[v].ovf});
            check("R4/R9 irq", {7'd0, irq}, {7'd0, VEC[v].aack});
        end

        // R2 and R8: address byte status, then data byte status
        host_clean();
        bus_start();
        send_byte({OWN, 1'b0}, a);
        check("R2 ack", {7'd0, a}, 8'd1);
        check("R2 buffer", rx_data, 8'hB4);
        check("R2 dir", {7'd0, st_dir}, 8'd0);
        check("R8 addr kind", {7'd0, st_data}, 8'd0);
        check("R4 irq after addr", {7'd0, irq}, 8'd1);
        pulse_irq();
        check("R4 irq cleared", {7'd0, irq}, 8'd0);
        pulse_rd();
        check("R5 read keeps data", rx_data, 8'hB4);
        send_byte(8'h5C, d);
        check("R8 data kind", {7'd0, st_data}, 8'd1);
        check("R4 irq after data", {7'd0, irq}, 8'd1);
        bus_stop();

        // R7: lost-byte set, holding register read, lost-byte not cleared
        host_clean();
        bus_start();
        send_byte({OWN, 1'b0}, a);
        send_byte(8'h11, d);
        check("R6 refused", {7'd0, d}, 8'd0);
        check("R6 kept", rx_data, 8'hB4);
        pulse_rd();
        send_byte(8'h99, d);
        check("R7 nack", {7'd0, d}, 8'd0);
        check("R7 stored", rx_data, 8'h99);
        check("R7 full", {7'd0, st_full}, 8'd1);
        check("R7 ovf kept", {7'd0, st_ovf}, 8'd1);
        bus_stop();
        pulse_ovf();
        check("R6 ovf cleared", {7'd0, st_ovf}, 8'd0);

        // R10: read-direction address
        host_clean();
        bus_start();
        send_byte({OWN, 1'b1}, a);
        check("R10 ack", {7'd0, a}, 8'd1);
        check("R10 dir", {7'd0, st_dir}, 8'd1);
        check("R10 buffer", rx_data, 8'hB5);
        pulse_rd(); pulse_irq();
        send_byte(8'h22, d);
        check("R10 no receive ack", {7'd0, d}, 8'd0);
        check("R10 no receive irq", {7'd0, irq}, 8'd0);
        check("R10 buffer kept", rx_data, 8'hB5);
        bus_stop();

        // R1: bytes after STOP are ignored
        host_clean();
        send_byte({OWN, 1'b0}, a);
        check("R1 no ack after stop", {7'd0, a}, 8'd0);
        check("R1 no irq after stop", {7'd0, irq}, 8'd0);

        // R11: repeated START mid-byte
        host_clean();
        bus_start();
        send_byte({OWN, 1'b0}, a);
        pulse_rd();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        check("R11 re-addressed ack", {7'd0, a}, 8'd1);
        pulse_rd();
        send_byte(8'h6E, d);
        check("R11 data", rx_data, 8'h6E);
        check("R11 data ack", {7'd0, d}, 8'd1);
        bus_stop();

        // R9: bytes after a mismatch leave flags untouched
        host_clean();
        bus_start();
        send_byte({7'h5B, 1'b0}, a);
        send_byte({OWN, 1'b0}, d);
        check("R9 no ack", {7'd0, a | d}, 8'd0);
        check("R9 full", {7'd0, st_full}, 8'd0);
        check("R9 irq", {7'd0, irq}, 8'd0);
        check("R9 buffer", rx_data, 8'h6E);
        bus_stop();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule